// File: doc/BRIEF.md
# Receive Word Queue with Threshold Request

This block holds data words between a serial receiver and the host. Each time the receive shifter finishes a word, it raises a one-cycle strobe with that word. The block then stores the word in a first-in, first-out queue. The host removes words through a pop port. It can read the live occupancy count at any moment. Reading the count has no side effects. A word that the shifter is still assembling never reaches this block, so the count covers only finished words.

The count is compared against a programmable threshold, here called the watermark. When the count is at or above the watermark, the block raises one request line. A select bit chooses between the DMA request line and the interrupt line. The interrupt line is also gated by its own enable bit. Both request lines are levels. They drop in the same cycle that the count falls below the watermark.

If a word arrives while the queue is full, the word is discarded and a sticky overrun flag is set. The host clears the flag with a one-cycle clear pulse.

Top module: `rx_water_fifo`

## Requirements
- R1: After reset, `rx_count` is 0, `pop_data` is 0, and `irq_req`, `dma_req` and `overrun` are low.
- R2: A push accepted at a clock edge raises `rx_count` by one from the next cycle on. `rx_count` never exceeds DEPTH.
- R3: Words leave in arrival order. A pop of a non-empty queue shows the oldest word on `pop_data` from the next cycle on.
- R4: A push and a pop in the same cycle on a non-empty queue leave `rx_count` unchanged. When the queue is full, the push is still accepted in that case.
- R5: A push into a full queue with no pop is dropped and sets `overrun`. `overrun` stays set until an `ovr_clr` pulse. A new overflow in the same cycle as the clear wins, so the flag stays set.
- R6: A pop of an empty queue leaves `rx_count` unchanged and holds `pop_data` at its previous value.
- R7: With `dma_sel` = 1, `dma_req` equals (`rx_count` >= `watermark`) and `irq_req` is low.
- R8: With `dma_sel` = 0, `irq_req` equals (`rx_count` >= `watermark`) AND `rx_irq_en`, and `dma_req` is low.
- R9: Once a pop takes `rx_count` below `watermark`, the active request line is low in the first cycle after that pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_vld | input | 1 | Word-complete strobe from the receive shifter |
| push_data | input | 8 | Completed word |
| pop | input | 1 | Host removes the oldest word |
| pop_data | output | 8 | Last word popped (registered) |
| rx_count | output | 8 | Number of stored words |
| watermark | input | 8 | Request threshold, valid from 1 to DEPTH-1 |
| dma_sel | input | 1 | 1: request goes to `dma_req`; 0: request goes to `irq_req` |
| rx_irq_en | input | 1 | Enable for the interrupt path |
| ovr_clr | input | 1 | Clears the overrun flag |
| overrun | output | 1 | Sticky flag: a word was dropped |
| irq_req | output | 1 | Threshold interrupt request |
| dma_req | output | 1 | Threshold DMA request |

## Verification
The bench builds the block with DEPTH = 6. This is not a power of two, so the read and write pointers must wrap at a bound that is not a natural counter rollover. The queue is shallow enough that random traffic often reaches both full and empty. As a result, overflow, simultaneous push and pop at full, and pops of an empty queue all occur many times. Random watermarks across 1 to 5 let the threshold edge move across the entire usable range.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef logic [7:0] cnt_t;

  // Next occupancy from the accepted push and pop of this cycle.
  function automatic cnt_t cnt_step(cnt_t c, logic inc, logic dec);
    case ({inc, dec})
      2'b10:   return c + 8'd1;
      2'b01:   return c - 8'd1;
      default: return c;
    endcase
  endfunction

  // Pointer advance with wrap at an arbitrary depth.
  function automatic int unsigned ptr_adv(int unsigned p, int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

  function automatic logic level_met(cnt_t c, cnt_t wm);
    return c >= wm;
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 8,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data
);
  import rxq_pkg::*;
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      rd_data <= '0;
    end else begin
      if (wr_en) wptr <= PW'(ptr_adv(int'(wptr), DEPTH));
      if (rd_en) begin
        rd_data <= mem[rptr];
        rptr    <= PW'(ptr_adv(int'(rptr), DEPTH));
      end
    end
  end

  p_ptr_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(wptr) < DEPTH) && (int'(rptr) < DEPTH));
endmodule

// File: rtl/rxq_counter.sv
module rxq_counter #(
  parameter int DEPTH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push,
  input  logic           pop,
  input  logic           ovr_clr,
  output rxq_pkg::cnt_t  count,
  output logic           push_ok,
  output logic           pop_ok,
  output logic           overrun
);
  import rxq_pkg::*;
  localparam cnt_t CAP = cnt_t'(DEPTH);

  logic full, empty, drop_evt;

  assign full     = (count == CAP);
  assign empty    = (count == '0);
  assign pop_ok   = pop && !empty;
  assign push_ok  = push && (!full || pop_ok);
  assign drop_evt = push && !push_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      overrun <= 1'b0;
    end else begin
      count <= cnt_step(count, push_ok, pop_ok);
      if (drop_evt)     overrun <= 1'b1;
      else if (ovr_clr) overrun <= 1'b0;
    end
  end

  p_count_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CAP);
  p_pair_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !empty) |=> $stable(count));
  p_drop_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> overrun);
  p_empty_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && empty) |=> (count == '0));
endmodule

// File: rtl/rxq_steer.sv
module rxq_steer (
  input  logic          clk,
  input  logic          rst_n,
  input  rxq_pkg::cnt_t count,
  input  rxq_pkg::cnt_t watermark,
  input  logic          dma_sel,
  input  logic          irq_en,
  output logic          irq_req,
  output logic          dma_req
);
  import rxq_pkg::*;
  logic hit;

  assign hit     = level_met(count, watermark);
  assign dma_req = hit && dma_sel;
  assign irq_req = hit && !dma_sel && irq_en;

  p_one_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_req && dma_req));
  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_en && !dma_sel));
endmodule

// File: rtl/rx_water_fifo.sv
module rx_water_fifo #(
  parameter int DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push_vld,
  input  logic [7:0] push_data,
  input  logic       pop,
  output logic [7:0] pop_data,
  output logic [7:0] rx_count,
  input  logic [7:0] watermark,
  input  logic       dma_sel,
  input  logic       rx_irq_en,
  input  logic       ovr_clr,
  output logic       overrun,
  output logic       irq_req,
  output logic       dma_req
);
  import rxq_pkg::*;

  logic push_ok, pop_ok;
  cnt_t count;

  rxq_counter #(.DEPTH(DEPTH)) u_cnt (
    .clk(clk), .rst_n(rst_n), .push(push_vld), .pop(pop), .ovr_clr(ovr_clr),
    .count(count), .push_ok(push_ok), .pop_ok(pop_ok), .overrun(overrun)
  );

  rxq_store #(.DEPTH(DEPTH), .DW(8)) u_mem (
    .clk(clk), .rst_n(rst_n), .wr_en(push_ok), .wr_data(push_data),
    .rd_en(pop_ok), .rd_data(pop_data)
  );

  rxq_steer u_req (
    .clk(clk), .rst_n(rst_n), .count(count), .watermark(watermark),
    .dma_sel(dma_sel), .irq_en(rx_irq_en), .irq_req(irq_req), .dma_req(dma_req)
  );

  assign rx_count = count;

  p_req_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count < watermark) |-> !(irq_req || dma_req));
  p_hold_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pop_ok |=> $stable(pop_data));
endmodule

// File: tb/tb_rx_water_fifo.sv
module tb_rx_water_fifo;
  localparam int DEPTH = 6;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 150000;

  logic clk = 0, rst_n = 0;
  logic push_vld = 0, pop = 0, dma_sel = 0, rx_irq_en = 0, ovr_clr = 0;
  logic [7:0] push_data = 0, watermark = 8'd3;
  logic [7:0] pop_data, rx_count;
  logic overrun, irq_req, dma_req;

  int n_chk = 0, n_fail = 0, cycles = 0;
  bit done = 0;
  int q[$];
  logic [7:0] e_pd = 0;
  logic e_ovr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_water_fifo #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .push_vld(push_vld), .push_data(push_data),
    .pop(pop), .pop_data(pop_data), .rx_count(rx_count), .watermark(watermark),
    .dma_sel(dma_sel), .rx_irq_en(rx_irq_en), .ovr_clr(ovr_clr),
    .overrun(overrun), .irq_req(irq_req), .dma_req(dma_req)
  );

  function automatic bit exp_irq(int c, int wm, bit ds, bit ie);
    return (c >= wm) && !ds && ie;
  endfunction
  function automatic bit exp_dma(int c, int wm, bit ds);
    return (c >= wm) && ds;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R2 count", rx_count, q.size());
    chk("R3 pop_data order", pop_data, e_pd);
    chk("R5 overrun", overrun, e_ovr);
    chk(dma_sel ? "R7 dma_req" : "R8 dma_req", dma_req,
        exp_dma(q.size(), watermark, dma_sel));
    chk(dma_sel ? "R7 irq_req" : "R8 irq_req", irq_req,
        exp_irq(q.size(), watermark, dma_sel, rx_irq_en));
  endtask

  task automatic step(bit ps, logic [7:0] d, bit pp, bit clr);
    bit pop_ok, push_ok;
    @(negedge clk);
    push_vld = ps; push_data = d; pop = pp; ovr_clr = clr;
    pop_ok  = pp && (q.size() != 0);
    push_ok = ps && ((q.size() < DEPTH) || pop_ok);
    if (pop_ok) e_pd = 8'(q.pop_front());
    if (push_ok) q.push_back(int'(d));
    if (ps && !push_ok) e_ovr = 1;
    else if (clr) e_ovr = 0;
    @(posedge clk); #1;
    check_all();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual %0d expected < %0d cycles", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    int depth_before;
    seed = 32'd20240611;
    void'($urandom(seed));
    #(CLK_PERIOD*2 + 1);
    // R1: reset state
    chk("R1 count", rx_count, 0);
    chk("R1 pop_data", pop_data, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 irq_req", irq_req, 0);
    chk("R1 dma_req", dma_req, 0);
    @(negedge clk); rst_n = 1;

    // R6: pop of an empty queue
    step(0, 8'h00, 1, 0);
    chk("R6 empty pop count", rx_count, 0);
    chk("R6 empty pop data", pop_data, 0);

    // R2/R7: fill to threshold with dma path
    dma_sel = 1; watermark = 8'd3;
    step(1, 8'h11, 0, 0);
    step(1, 8'h22, 0, 0);
    chk("R7 below mark", dma_req, 0);
    step(1, 8'h33, 0, 0);
    chk("R7 at mark", dma_req, 1);
    // R8: interrupt path gated
    dma_sel = 0; rx_irq_en = 0; #1;
    chk("R8 irq gated off", irq_req, 0);
    rx_irq_en = 1; #1;
    chk("R8 irq enabled", irq_req, 1);
    // R9: pop takes count below mark
    step(0, 8'h00, 1, 0);
    chk("R9 req dropped", irq_req, 0);
    chk("R3 first word", pop_data, 8'h11);
    // fill to full, then overflow (R5)
    step(1, 8'h44, 0, 0); step(1, 8'h55, 0, 0);
    step(1, 8'h66, 0, 0); step(1, 8'h77, 0, 0);
    chk("R2 full", rx_count, DEPTH);
    step(1, 8'h88, 0, 0);
    chk("R5 drop keeps count", rx_count, DEPTH);
    chk("R5 overrun set", overrun, 1);
    // R4: push and pop at full
    step(1, 8'h99, 1, 0);
    chk("R4 pair at full", rx_count, DEPTH);
    // R5: overflow wins over clear, then clear
    step(1, 8'hAA, 0, 1);
    chk("R5 set beats clear", overrun, 1);
    step(0, 8'h00, 0, 1);
    chk("R5 cleared", overrun, 0);
    // drain past empty
    for (int i = 0; i < DEPTH + 2; i++) step(0, 8'h00, 1, 0);
    chk("R6 drained", rx_count, 0);
    // R4: push+pop on empty: only push takes effect
    step(1, 8'h5A, 1, 0);
    chk("R4 empty pair", rx_count, 1);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      if (n % 250 == 0) watermark = 8'(1 + ($urandom % (DEPTH - 1)));
      dma_sel = 1'($urandom);
      rx_irq_en = 1'($urandom);
      depth_before = q.size();
      step(($urandom % 100) < 55, 8'($urandom), ($urandom % 100) < 45,
           ($urandom % 100) < 5);
      if (depth_before < 0) chk("R2 sanity", depth_before, 0);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule